// File: doc/BRIEF.md
# Trigger Throttle with Backlog Watchdog

This block keeps a running tally of accepted triggers that still wait for readout. Each accept pulse adds one to the tally, and each readout-done pulse takes one away. When the tally reaches a fixed limit, the block drives an active-low inhibit back to the trigger source so that no more accepts arrive.

The inhibit does not clear just because the tally falls. When the inhibit is raised, a 16-bit watchdog loads a programmable preload and counts down once per clock. When the watchdog expires, the inhibit clears if the tally has drained to zero. If the tally is still above zero, a sticky error flag is raised and the inhibit stays in force until the tally next reads zero. The host clears the error with a one-cycle strobe.

A second, independent function merges a set of active-low busy lines from downstream collectors into a single active-low busy output.

Top module: `trig_throttle`

## Requirements
- R1: `backlog` rises by one on the clock edge that samples `acc_pulse` alone and falls by one on the edge that samples `done_pulse` alone. When both pulses are sampled together it does not change.
- R2: `backlog` saturates. It stays at 7 on a lone accept and stays at 0 on a lone done.
- R3: `inhibit_n` goes low on the same edge at which `backlog` becomes 5 or more, and it stays low while `backlog` is 5 or more.
- R4: On the inhibit edge, the watchdog loads `wd_preload` and then counts down once per cycle. It expires in the cycle after it reaches zero, which is preload+1 cycles after loading. If `backlog` is 0 then, `inhibit_n` returns high on that edge. Before expiry, `inhibit_n` stays low even if `backlog` has dropped to 0.
- R5: If the watchdog expires with `backlog` nonzero, `inhibit_n` stays low. It returns high on the edge after the first cycle in which `backlog` reads 0.
- R6: `cnt_err` is set on the expiry edge when `backlog` is nonzero. It holds until an edge samples `err_clr`. If setting and clearing happen in the same cycle, setting wins.
- R7: `busy_all_n` is low, combinationally, exactly when at least one bit of `busy_n` is low.
- R8: After reset, `backlog` is 0, `inhibit_n` is 1, `cnt_err` is 0 and the watchdog is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one watchdog count per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_pulse | input | 1 | One-cycle accept pulse |
| done_pulse | input | 1 | One-cycle readout-done pulse |
| busy_n | input | NBUSY (4) | Active-low busy lines |
| wd_preload | input | TW (16) | Watchdog start value |
| err_clr | input | 1 | Error-clear strobe |
| backlog | output | 3 | Events awaiting readout |
| inhibit_n | output | 1 | Active-low inhibit to the trigger source |
| busy_all_n | output | 1 | Merged active-low busy |
| cnt_err | output | 1 | Sticky drain error |

## Verification
The assertions assume that `acc_pulse`, `done_pulse` and `err_clr` are synchronous to `clk` and stable around its rising edge. They also assume that `wd_preload` does not change on the edge at which the inhibit is raised. The bench drives every input on the falling edge and changes `wd_preload` only while the block is idle. The assertions make no assumption that the source obeys the inhibit. For that reason the stimulus deliberately keeps accepting while inhibited, which drives the tally into saturation at 7.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // saturating up/down step of the backlog tally
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    if (up && !dn && c != CNT_MAX) return c + 1'b1;
    if (dn && !up && c != '0)      return c - 1'b1;
    return c;
  endfunction

  function automatic logic at_limit(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] lim);
    return c >= lim;
  endfunction
endpackage

// File: rtl/thr_backlog.sv
module thr_backlog
  import thr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             done,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx
);
  assign cnt_nx = cnt_step(cnt_q, acc, done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;

  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !done && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == done) |=> $stable(cnt_q));
  p_sat_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !done) |=> cnt_q == CNT_MAX);
  p_sat_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !acc) |=> cnt_q == '0);
endmodule

// File: rtl/thr_watchdog.sv
module thr_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] preload,
  output logic          run_q,
  output logic          expire
);
  logic [TW-1:0] wd_q;

  assign expire = run_q && (wd_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_q  <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      wd_q  <= preload;
      run_q <= 1'b1;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      wd_q  <= wd_q - 1'b1;
    end

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q && wd_q == $past(preload));
  p_expire_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !run_q);
endmodule

// File: rtl/thr_busy_merge.sv
module thr_busy_merge #(
  parameter int NBUSY = 4
) (
  input  logic [NBUSY-1:0] busy_n,
  output logic             all_n
);
  logic [NBUSY:0] any;
  assign any[0] = 1'b0;

  for (genvar i = 0; i < NBUSY; i++) begin : g_or
    assign any[i+1] = any[i] | ~busy_n[i];
  end

  assign all_n = ~any[NBUSY];

  always_comb
    p_merge_r7: assert (all_n == ($countones(~busy_n) == 0));
endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
  import thr_pkg::*;
#(
  parameter int TW    = 16,
  parameter int NBUSY = 4,
  parameter int LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_pulse,
  input  logic             done_pulse,
  input  logic [NBUSY-1:0] busy_n,
  input  logic [TW-1:0]    wd_preload,
  input  logic             err_clr,
  output logic [2:0]       backlog,
  output logic             inhibit_n,
  output logic             busy_all_n,
  output logic             cnt_err
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic inh_q, err_q, run_q, expire;
  logic inh_start, inh_release, err_set;

  thr_backlog u_cnt (
    .clk(clk), .rst_n(rst_n), .acc(acc_pulse), .done(done_pulse),
    .cnt_q(cnt_q), .cnt_nx(cnt_nx));

  thr_watchdog #(.TW(TW)) u_wd (
    .clk(clk), .rst_n(rst_n), .start(inh_start), .preload(wd_preload),
    .run_q(run_q), .expire(expire));

  thr_busy_merge #(.NBUSY(NBUSY)) u_busy (
    .busy_n(busy_n), .all_n(busy_all_n));

  // named events for the assertions
  assign inh_start   = !inh_q && at_limit(cnt_nx, LIM);
  assign inh_release = inh_q && (expire || !run_q) && (cnt_q == '0);
  assign err_set     = expire && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      inh_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (inh_start)        inh_q <= 1'b1;
      else if (inh_release) inh_q <= 1'b0;
      if (err_set)          err_q <= 1'b1;
      else if (err_clr)     err_q <= 1'b0;
    end

  assign backlog   = cnt_q;
  assign inhibit_n = ~inh_q;
  assign cnt_err   = err_q;

  p_full_inhibits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= LIM) |-> !inhibit_n);
  p_hold_while_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !expire && !inhibit_n) |=> !inhibit_n);
  p_release_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_n) |-> $past(cnt_q) == '0);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_err && !err_clr) |=> cnt_err);
  p_err_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cnt_q != '0) |=> cnt_err);
endmodule

// File: tb/trig_throttle_test.sv
module trig_throttle_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, acc, done, clr;
  logic [3:0] busy_n;
  logic [15:0] pre;
  logic [2:0] backlog;
  logic inhibit_n, busy_all_n, cnt_err;

  trig_throttle uut (
    .clk(clk), .rst_n(rst_n), .acc_pulse(acc), .done_pulse(done),
    .busy_n(busy_n), .wd_preload(pre), .err_clr(clr),
    .backlog(backlog), .inhibit_n(inhibit_n), .busy_all_n(busy_all_n),
    .cnt_err(cnt_err));

  typedef struct { int cnt; bit inh_n; bit err; string tag; } exp_t;
  exp_t sb[$];
  exp_t e;
  int checks = 0, fails = 0;

  // bench model state
  int m_cnt = 0, m_wd = 0;
  bit m_inh = 0, m_run = 0, m_err = 0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit a, bit d, bit c, string tag);
    int nc;
    bit ex, st, ni, ne;
    exp_t x;
    @(negedge clk);
    acc = a; done = d; clr = c;
    nc = m_cnt;
    if (a && !d && nc < 7) nc++;
    else if (d && !a && nc > 0) nc--;
    ex = m_run && (m_wd == 0);
    st = !m_inh && (nc >= 5);
    ni = m_inh;
    if (st) ni = 1;
    else if (m_inh && m_cnt == 0 && (ex || !m_run)) ni = 0;
    ne = m_err;
    if (ex && m_cnt != 0) ne = 1;
    else if (c) ne = 0;
    if (st) begin m_wd = pre; m_run = 1; end
    else if (ex) m_run = 0;
    else if (m_run) m_wd--;
    m_cnt = nc; m_inh = ni; m_err = ne;
    x.cnt = nc; x.inh_n = !ni; x.err = ne; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag, "backlog", int'(backlog), e.cnt);
      check(e.tag, "inhibit_n", int'(inhibit_n), int'(e.inh_n));
      check(e.tag, "cnt_err", int'(cnt_err), int'(e.err));
    end
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; acc = 0; done = 0; clr = 0; busy_n = 4'hF; pre = 16'd10;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "backlog", int'(backlog), 0);
    check("R8", "inhibit_n", int'(inhibit_n), 1);
    check("R8", "cnt_err", int'(cnt_err), 0);
    // R7 busy merge patterns
    #1 check("R7", "busy_all_n 1111", int'(busy_all_n), 1);
    busy_n = 4'b1110; #1 check("R7", "busy_all_n 1110", int'(busy_all_n), 0);
    busy_n = 4'b0111; #1 check("R7", "busy_all_n 0111", int'(busy_all_n), 0);
    busy_n = 4'b1011; #1 check("R7", "busy_all_n 1011", int'(busy_all_n), 0);
    busy_n = 4'b0000; #1 check("R7", "busy_all_n 0000", int'(busy_all_n), 0);
    busy_n = 4'b1111; #1 check("R7", "busy_all_n 1111b", int'(busy_all_n), 1);
    @(negedge clk); rst_n = 1;

    // R1 counting, simultaneous pulses
    step(1, 0, 0, "R1"); step(1, 0, 0, "R1"); step(1, 1, 0, "R1");
    step(0, 1, 0, "R1"); step(0, 1, 0, "R1");
    // R2 floor saturation
    step(0, 1, 0, "R2"); step(1, 1, 0, "R2");
    // R3 inhibit at limit, R4 drain before expiry keeps inhibit
    pre = 16'd10;
    repeat (5) step(1, 0, 0, "R3");
    repeat (5) step(0, 1, 0, "R4");
    idle(10, "R4");
    // R5 / R2 / R6: expiry with nonzero backlog, saturation at top
    pre = 16'd3;
    repeat (8) step(1, 0, 0, "R5");
    idle(4, "R6");
    repeat (7) step(0, 1, 0, "R5");
    idle(3, "R5");
    step(0, 0, 1, "R6");
    idle(2, "R6");
    // R4 zero preload: expiry one cycle after loading
    pre = 16'd0;
    repeat (5) step(1, 0, 0, "R4");
    idle(2, "R6");
    step(0, 0, 1, "R6");
    repeat (5) step(0, 1, 0, "R5");
    idle(3, "R5");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule